// File: doc/BRIEF.md
# ALU Pipeline with Operand Forwarding

This block is a five-stage integer pipeline (fetch, decode, execute, memory, writeback) that executes register-to-register arithmetic and logic words. One instruction word enters per clock. The memory stage only carries results forward. Branches, loads, stalls and data memory are not part of it. The design centres on the bypass network. Every stage register carries the source and destination register numbers and a write flag. A forwarding unit compares the numbers of the instruction in execute with those of the two older instructions further down the pipe. Its decisions steer two three-way multiplexers in front of the ALU. A younger instruction can therefore use a result one or two instructions after it was computed, before that result reaches the register file.

The register file performs its write early in the cycle and its reads late in the cycle. It does this as an internal write-through path, so a reader three instructions behind a producer needs no bypass. The writeback port, the two multiplexer selects and a side read port into the register file are brought out so that a test environment can observe them.

Top module: `fwd_alu_pipe`

## Requirements
- R1: An instruction word is decoded with the opcode in bits 31:26, which must be 0, then rs in 25:21, rt in 20:16, rd in 15:11 and the function code in 5:0. The function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, and 0x2A slt. slt is a signed compare that gives 1 or 0. Any other word is a bubble and writes nothing.
- R2: While `rst` is high, all stage registers are cleared to bubbles with the write flag low, and register i of the register file is loaded with the value i. After release, `wb_en` stays low until a real instruction reaches writeback. An instruction in flight when reset is asserted is discarded.
- R3: An instruction sampled on `instr_in` at rising edge k shows its result on `wb_en`/`wb_addr`/`wb_data` after edge k+3. It is committed to the register file at edge k+4. Results leave in program order.
- R4: Each operand select is a 2-bit code: 00 takes the register-file read from decode, 10 takes the ALU result in the execute/memory register, and 01 takes the result in the memory/writeback register. Code 11 never occurs.
- R5: Operand A uses the execute/memory result when that stage's write flag is set, its rd is nonzero and its rd equals the rs of the instruction in execute. Operand B uses the same rule with rt.
- R6: The memory/writeback result is selected when that stage's write flag is set, its rd is nonzero and its rd matches the source, but only if the execute/memory condition for that operand is false. The newer result always wins.
- R7: Register 0 is never forwarded, is never written and always reads as zero, even when an instruction targets it with its write flag set. `wb_en` is never raised for rd 0.
- R8: A read of the register being written in the same cycle returns the incoming data, so an instruction three positions after its producer gets the new value through select 00.
- R9: Operands A and B are resolved independently and may be forwarded in the same cycle from different stages.
- R10: `peek_data` returns, combinationally, the committed content of register `peek_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_in | input | 32 | Instruction word sampled each cycle |
| wb_en | output | 1 | Writeback of a nonzero register this cycle |
| wb_addr | output | 5 | Register being written back |
| wb_data | output | XLEN | Value being written back |
| fwd_sel_a | output | 2 | Operand A select of the instruction in execute |
| fwd_sel_b | output | 2 | Operand B select of the instruction in execute |
| peek_addr | input | 5 | Side read address into the register file |
| peek_data | output | XLEN | Committed content of `peek_addr` |

## Verification
On every cycle the assertions check the following. No select code is 11. A zero destination never produces a forwarding select. An execute/memory match always overrides memory/writeback. A writeback select is only chosen when memory/writeback really holds that register. The writeback port follows the execute/memory stage by one cycle and never shows register 0. Only the bench's programs can show that the forwarded values are numerically right. They cover producer distances of one, two and three, a triple overwrite of one register, writes aimed at register 0, a bubble whose rd field matches a later source, and a reset that drops an instruction in flight. The bench checks them against a sequential reference model.

// File: rtl/fwdp_pkg.sv
package fwdp_pkg;

   // Register-number field width and instruction width (format-defined)
   localparam int unsigned RA_W = 5;
   localparam int unsigned ILEN = 32;

   // Function codes of the supported R-type operations
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      OP_ADD,
      OP_SUB,
      OP_AND,
      OP_OR,
      OP_SLT
   } alu_op_e;

   // Operand source codes driven to the ALU input multiplexers
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_WB  = 2'b01,
      SEL_EXM = 2'b10
   } fwd_sel_e;

   // Control part of an instruction as it moves down the pipe
   typedef struct packed {
      logic            wr;
      alu_op_e         op;
      logic [RA_W-1:0] rs;
      logic [RA_W-1:0] rt;
      logic [RA_W-1:0] rd;
   } uop_t;

   localparam uop_t UOP_BUBBLE = '{wr: 1'b0, op: OP_ADD, rs: '0, rt: '0, rd: '0};

   function automatic uop_t decode_word(input logic [ILEN-1:0] w);
      uop_t u;
      u.rs = w[25:21];
      u.rt = w[20:16];
      u.rd = w[15:11];
      u.wr = (w[31:26] == 6'd0);
      u.op = OP_ADD;
      case (w[5:0])
         FN_ADD:  u.op = OP_ADD;
         FN_SUB:  u.op = OP_SUB;
         FN_AND:  u.op = OP_AND;
         FN_OR:   u.op = OP_OR;
         FN_SLT:  u.op = OP_SLT;
         default: u.wr = 1'b0;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/fwdp_regfile.sv
module fwdp_regfile
   import fwdp_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NREG    = 32,
   parameter int unsigned NRD     = 2,
   parameter bit          WR_THRU = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we,
   input  logic [RA_W-1:0]      waddr,
   input  logic [XLEN-1:0]      wdata,
   input  logic [NRD*RA_W-1:0]  raddr,
   output logic [NRD*XLEN-1:0]  rdata,
   input  logic [RA_W-1:0]      paddr,
   output logic [XLEN-1:0]      pdata
);

   if (NREG != (2 ** RA_W)) begin : g_bad_nreg
      $error("fwdp_regfile: NREG must equal the register-field range");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("fwdp_regfile: at least one read port is required");
   end

   logic [XLEN-1:0] mem [NREG];

   // Reset preloads each register with its own index; register 0 is never written
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(NREG); i++) begin
            mem[i] <= XLEN'(i);
         end
      end else if (we && (waddr != '0)) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
      logic [RA_W-1:0] a;
      logic [XLEN-1:0] stored;
      assign a      = raddr[p*RA_W +: RA_W];
      assign stored = (a == '0) ? '0 : mem[a];
      if (WR_THRU) begin : g_thru
         // Early-write/late-read behaviour: a same-cycle write is seen by the read
         assign rdata[p*XLEN +: XLEN] = (we && (a != '0) && (a == waddr)) ? wdata : stored;
      end else begin : g_plain
         assign rdata[p*XLEN +: XLEN] = stored;
      end
   end

   assign pdata = (paddr == '0) ? '0 : mem[paddr];

endmodule

// File: rtl/fwdp_fwd_unit.sv
module fwdp_fwd_unit
   import fwdp_pkg::*;
#(
   parameter int unsigned NSRC = 2
) (
   input  logic [NSRC*RA_W-1:0] src,
   input  logic                 exm_wr,
   input  logic [RA_W-1:0]      exm_rd,
   input  logic                 mwb_wr,
   input  logic [RA_W-1:0]      mwb_rd,
   output logic [NSRC*2-1:0]    sel
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("fwdp_fwd_unit: NSRC must be at least 1");
   end

   logic exm_live;
   logic mwb_live;

   // A stage can forward only if it writes and its target is not register 0
   assign exm_live = exm_wr && (exm_rd != '0);
   assign mwb_live = mwb_wr && (mwb_rd != '0);

   for (genvar s = 0; s < int'(NSRC); s++) begin : g_lane
      logic [RA_W-1:0] num;
      logic            hit_exm;
      logic            hit_mwb;
      fwd_sel_e        pick;
      assign num     = src[s*RA_W +: RA_W];
      assign hit_exm = exm_live && (exm_rd == num);
      assign hit_mwb = mwb_live && (mwb_rd == num);
      // Newer result (execute/memory) has priority over the older one
      assign pick    = hit_exm ? SEL_EXM : (hit_mwb ? SEL_WB : SEL_RF);
      assign sel[s*2 +: 2] = pick;
   end

endmodule

// File: rtl/fwdp_alu.sv
module fwdp_alu
   import fwdp_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_SLT:  y = XLEN'($signed(a) < $signed(b));
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/fwd_alu_pipe.sv
module fwd_alu_pipe
   import fwdp_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NREG    = 32,
   parameter bit          WR_THRU = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ILEN-1:0] instr_in,
   output logic            wb_en,
   output logic [RA_W-1:0] wb_addr,
   output logic [XLEN-1:0] wb_data,
   output logic [1:0]      fwd_sel_a,
   output logic [1:0]      fwd_sel_b,
   input  logic [RA_W-1:0] peek_addr,
   output logic [XLEN-1:0] peek_data
);

   localparam int unsigned NOPND = 2;

   if (XLEN < 2) begin : g_bad_xlen
      $error("fwd_alu_pipe: XLEN must be at least 2");
   end

   // ---------------- fetch -> decode ----------------
   logic [ILEN-1:0] ifid_word;

   always_ff @(posedge clk) begin
      if (rst) ifid_word <= '0;        // all-zero word decodes as a bubble
      else     ifid_word <= instr_in;
   end

   // ---------------- decode ----------------
   uop_t                  dec_u;
   logic [NOPND*XLEN-1:0] rf_rdata;
   logic                  mwb_wr;
   logic [RA_W-1:0]       mwb_rd;
   logic [XLEN-1:0]       mwb_res;

   assign dec_u = decode_word(ifid_word);

   fwdp_regfile #(
      .XLEN    (XLEN),
      .NREG    (NREG),
      .NRD     (NOPND),
      .WR_THRU (WR_THRU)
   ) rf_i (
      .clk   (clk),
      .rst   (rst),
      .we    (mwb_wr),
      .waddr (mwb_rd),
      .wdata (mwb_res),
      .raddr ({dec_u.rt, dec_u.rs}),
      .rdata (rf_rdata),
      .paddr (peek_addr),
      .pdata (peek_data)
   );

   // ---------------- decode -> execute ----------------
   uop_t            idex_u;
   logic [XLEN-1:0] idex_a;
   logic [XLEN-1:0] idex_b;

   always_ff @(posedge clk) begin
      if (rst) begin
         idex_u <= UOP_BUBBLE;
         idex_a <= '0;
         idex_b <= '0;
      end else begin
         idex_u <= dec_u;
         idex_a <= rf_rdata[0 +: XLEN];
         idex_b <= rf_rdata[XLEN +: XLEN];
      end
   end

   // ---------------- execute ----------------
   logic [RA_W-1:0]    ex_rs;
   logic [RA_W-1:0]    ex_rt;
   logic [NOPND*2-1:0] sel_bus;
   logic               exm_wr;
   logic [RA_W-1:0]    exm_rd;
   logic [XLEN-1:0]    exm_res;
   logic [XLEN-1:0]    base_v [NOPND];
   logic [XLEN-1:0]    opnd_v [NOPND];
   logic [XLEN-1:0]    alu_y;

   assign ex_rs = idex_u.rs;
   assign ex_rt = idex_u.rt;

   fwdp_fwd_unit #(
      .NSRC (NOPND)
   ) fwd_i (
      .src    ({ex_rt, ex_rs}),
      .exm_wr (exm_wr),
      .exm_rd (exm_rd),
      .mwb_wr (mwb_wr),
      .mwb_rd (mwb_rd),
      .sel    (sel_bus)
   );

   assign base_v[0] = idex_a;
   assign base_v[1] = idex_b;

   for (genvar k = 0; k < int'(NOPND); k++) begin : g_opnd
      logic [1:0] s;
      assign s = sel_bus[k*2 +: 2];
      assign opnd_v[k] = (s == SEL_EXM) ? exm_res :
                         (s == SEL_WB)  ? mwb_res : base_v[k];
   end

   fwdp_alu #(
      .XLEN (XLEN)
   ) alu_i (
      .op (idex_u.op),
      .a  (opnd_v[0]),
      .b  (opnd_v[1]),
      .y  (alu_y)
   );

   assign fwd_sel_a = sel_bus[1:0];
   assign fwd_sel_b = sel_bus[3:2];

   // ---------------- execute -> memory ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         exm_wr  <= 1'b0;
         exm_rd  <= '0;
         exm_res <= '0;
      end else begin
         exm_wr  <= idex_u.wr;
         exm_rd  <= idex_u.rd;
         exm_res <= alu_y;
      end
   end

   // ---------------- memory -> writeback (no data memory: pass-through) ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         mwb_wr  <= 1'b0;
         mwb_rd  <= '0;
         mwb_res <= '0;
      end else begin
         mwb_wr  <= exm_wr;
         mwb_rd  <= exm_rd;
         mwb_res <= exm_res;
      end
   end

   assign wb_en   = mwb_wr && (mwb_rd != '0);
   assign wb_addr = mwb_rd;
   assign wb_data = mwb_res;

endmodule

// File: rtl/fwd_alu_pipe_chk.sv
module fwd_alu_pipe_chk
   import fwdp_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [RA_W-1:0] idex_rs,
   input logic [RA_W-1:0] idex_rt,
   input logic            exm_wr,
   input logic [RA_W-1:0] exm_rd,
   input logic            mwb_wr,
   input logic [RA_W-1:0] mwb_rd,
   input logic [1:0]      sel_a,
   input logic [1:0]      sel_b,
   input logic            wb_en,
   input logic [RA_W-1:0] wb_addr,
   input logic [RA_W-1:0] peek_addr,
   input logic [XLEN-1:0] peek_data
);

   // R4
   sel_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_a != 2'b11) && (sel_b != 2'b11));

   // R5
   exm_a_priority_chk: assert property (@(posedge clk) disable iff (rst)
      (exm_wr && (exm_rd != '0) && (exm_rd == idex_rs)) |-> (sel_a == 2'b10));

   // R9
   exm_b_priority_chk: assert property (@(posedge clk) disable iff (rst)
      (exm_wr && (exm_rd != '0) && (exm_rd == idex_rt)) |-> (sel_b == 2'b10));

   // R6
   wb_a_justified_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_a == 2'b01) |-> (mwb_wr && (mwb_rd == idex_rs)));

   // R6
   wb_b_justified_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_b == 2'b01) |-> (mwb_wr && (mwb_rd == idex_rt)));

   // R7
   zero_exm_src_chk: assert property (@(posedge clk) disable iff (rst)
      (exm_rd == '0) |-> ((sel_a != 2'b10) && (sel_b != 2'b10)));

   // R7
   zero_mwb_src_chk: assert property (@(posedge clk) disable iff (rst)
      (mwb_rd == '0) |-> ((sel_a != 2'b01) && (sel_b != 2'b01)));

   // R7
   wb_port_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> (wb_addr != '0));

   // R3
   wb_follows_exm_chk: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> ($past(exm_wr) && (wb_addr == $past(exm_rd))));

   // R2
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !wb_en);

   // R10
   peek_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (peek_addr == '0) |-> (peek_data == '0));

endmodule

bind fwd_alu_pipe fwd_alu_pipe_chk #(
   .XLEN (XLEN)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .idex_rs   (ex_rs),
   .idex_rt   (ex_rt),
   .exm_wr    (exm_wr),
   .exm_rd    (exm_rd),
   .mwb_wr    (mwb_wr),
   .mwb_rd    (mwb_rd),
   .sel_a     (fwd_sel_a),
   .sel_b     (fwd_sel_b),
   .wb_en     (wb_en),
   .wb_addr   (wb_addr),
   .peek_addr (peek_addr),
   .peek_data (peek_data)
);

// File: tb/fwd_alu_pipe_tb_top.sv
`timescale 1ns/1ps
module fwd_alu_pipe_tb_top;
   import fwdp_pkg::*;

   localparam int XL = 32;
   localparam int NP = 21;

   // Program table: {expected selA, expected selB, op, rd, rs, rt}
   // op: 0 add, 1 sub, 2 and, 3 or, 4 slt, 7 non-ALU word (bubble)
   localparam logic [21:0] PROG [NP] = '{
      {2'b00, 2'b00, 3'd1, 5'd2,  5'd1,  5'd3 },  // producer
      {2'b10, 2'b00, 3'd2, 5'd12, 5'd2,  5'd5 },  // distance 1 on A
      {2'b00, 2'b01, 3'd3, 5'd13, 5'd6,  5'd2 },  // distance 2 on B
      {2'b00, 2'b00, 3'd0, 5'd14, 5'd2,  5'd2 },  // distance 3, write-through
      {2'b00, 2'b00, 3'd4, 5'd15, 5'd2,  5'd7 },  // signed compare
      {2'b00, 2'b00, 3'd0, 5'd1,  5'd1,  5'd2 },  // triple write 1
      {2'b10, 2'b00, 3'd0, 5'd1,  5'd1,  5'd3 },  // triple write 2
      {2'b10, 2'b00, 3'd0, 5'd1,  5'd1,  5'd4 },  // triple write 3: newest wins
      {2'b10, 2'b10, 3'd0, 5'd16, 5'd1,  5'd1 },  // both from EX/MEM
      {2'b00, 2'b00, 3'd0, 5'd0,  5'd8,  5'd9 },  // write aimed at r0
      {2'b00, 2'b00, 3'd3, 5'd17, 5'd0,  5'd10},  // r0 guard in EX/MEM
      {2'b00, 2'b00, 3'd0, 5'd18, 5'd0,  5'd0 },  // r0 guard in MEM/WB
      {2'b00, 2'b00, 3'd0, 5'd20, 5'd11, 5'd12},
      {2'b00, 2'b00, 3'd1, 5'd21, 5'd13, 5'd4 },
      {2'b10, 2'b01, 3'd0, 5'd22, 5'd21, 5'd20},  // A and B from different stages
      {2'b10, 2'b01, 3'd4, 5'd23, 5'd22, 5'd21},
      {2'b00, 2'b00, 3'd4, 5'd24, 5'd2,  5'd0 },
      {2'b01, 2'b10, 3'd2, 5'd25, 5'd23, 5'd24},  // swapped stages
      {2'b00, 2'b00, 3'd7, 5'd5,  5'd0,  5'd0 },  // bubble naming rd 5
      {2'b00, 2'b00, 3'd0, 5'd27, 5'd5,  5'd5 },  // no forward from bubble
      {2'b00, 2'b00, 3'd3, 5'd26, 5'd25, 5'd3 }
   };

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [31:0]     instr_in = '0;
   logic            wb_en;
   logic [4:0]      wb_addr;
   logic [XL-1:0]   wb_data;
   logic [1:0]      fwd_sel_a;
   logic [1:0]      fwd_sel_b;
   logic [4:0]      peek_addr = '0;
   logic [XL-1:0]   peek_data;

   int nchk = 0;
   int nbad = 0;
   int cyc  = 0;
   bit done = 1'b0;

   logic [XL-1:0] ref_rf [32];
   logic [4:0]    exp_addr [64];
   logic [XL-1:0] exp_data [64];
   int            n_exp = 0;
   int            rd_ptr = 0;
   int            issue_cyc [NP];
   logic [1:0]    log_a [256];
   logic [1:0]    log_b [256];

   fwd_alu_pipe #(.XLEN(XL)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .instr_in  (instr_in),
      .wb_en     (wb_en),
      .wb_addr   (wb_addr),
      .wb_data   (wb_data),
      .fwd_sel_a (fwd_sel_a),
      .fwd_sel_b (fwd_sel_b),
      .peek_addr (peek_addr),
      .peek_data (peek_data)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] fcode(input logic [2:0] op);
      case (op)
         3'd0:    return 6'h20;
         3'd1:    return 6'h22;
         3'd2:    return 6'h24;
         3'd3:    return 6'h25;
         3'd4:    return 6'h2A;
         default: return 6'h00;
      endcase
   endfunction

   function automatic logic [XL-1:0] ref_alu(input logic [2:0] op, input logic [XL-1:0] a,
                                             input logic [XL-1:0] b);
      case (op)
         3'd0:    return a + b;
         3'd1:    return a - b;
         3'd2:    return a & b;
         3'd3:    return a | b;
         default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   // Writeback monitor and select logger, sampled away from the rising edge
   always @(negedge clk) begin
      log_a[cyc[7:0]] <= fwd_sel_a;
      log_b[cyc[7:0]] <= fwd_sel_b;
      if (!rst && wb_en) begin
         if (rd_ptr >= n_exp) begin
            check("R3 unexpected writeback addr", {27'd0, wb_addr}, 32'hFFFF_FFFF);
         end else begin
            check("R3 writeback addr order", {27'd0, wb_addr}, {27'd0, exp_addr[rd_ptr]});
            check("R3/R5/R6/R8 writeback data", wb_data, exp_data[rd_ptr]);
            rd_ptr++;
         end
      end
   end

   initial begin
      for (int r = 0; r < 32; r++) ref_rf[r] = XL'(r);

      // ---- reset state (R2) ----
      repeat (3) @(negedge clk);
      check("R2 wb_en low in reset", {31'd0, wb_en}, 32'd0);
      @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R2 wb_en low after release", {31'd0, wb_en}, 32'd0);
      check("R2 select A idle", {30'd0, fwd_sel_a}, 32'd0);
      peek_addr = 5'd9;
      #1 check("R2 r9 preloaded", peek_data, 32'd9);
      peek_addr = 5'd0;
      #1 check("R7 r0 reads zero", peek_data, 32'd0);

      // ---- table walk ----
      for (int i = 0; i < NP; i++) begin
         logic [2:0] op;
         logic [4:0] rd, rs, rt;
         op = PROG[i][17:15];
         rd = PROG[i][14:10];
         rs = PROG[i][9:5];
         rt = PROG[i][4:0];
         @(posedge clk);
         #1 instr_in = {6'd0, rs, rt, rd, 5'd0, fcode(op)};
         issue_cyc[i] = cyc;
         if (op <= 3'd4) begin
            logic [XL-1:0] v;
            v = ref_alu(op, ref_rf[rs], ref_rf[rt]);
            if (rd != 5'd0) begin
               ref_rf[rd] = v;
               exp_addr[n_exp] = rd;
               exp_data[n_exp] = v;
               n_exp++;
            end
         end
      end
      @(posedge clk);
      #1 instr_in = '0;
      repeat (8) @(posedge clk);
      @(negedge clk);

      check("R3 all results written back", rd_ptr, n_exp);

      // Select codes seen while each entry was in execute
      for (int i = 0; i < NP; i++) begin
         int c;
         c = (issue_cyc[i] + 2) % 256;
         check($sformatf("R4/R5/R6/R9 entry %0d select A", i), {30'd0, log_a[c]}, {30'd0, PROG[i][21:20]});
         check($sformatf("R4/R5/R6/R9 entry %0d select B", i), {30'd0, log_b[c]}, {30'd0, PROG[i][19:18]});
      end

      // Final register file against the sequential reference (R10 side port)
      for (int r = 0; r < 32; r++) begin
         peek_addr = 5'(r);
         #1 check($sformatf("R10/R1/R7/R8 final r%0d", r), peek_data, ref_rf[r]);
      end
      peek_addr = 5'd27;
      #1 check("R1 bubble did not write r5 (r27 = r5+r5)", peek_data, 32'd10);
      peek_addr = 5'd14;
      #1 check("R8 distance-3 reader r14", peek_data, 32'hFFFF_FFFC);

      // ---- reset drops an instruction in flight (R2) ----
      @(posedge clk);
      #1 instr_in = {6'd0, 5'd1, 5'd1, 5'd3, 5'd0, 6'h20};
      @(posedge clk);
      #1 begin
         instr_in = '0;
         rst = 1'b1;
      end
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R2 no writeback after reset", {31'd0, wb_en}, 32'd0);
      end
      peek_addr = 5'd3;
      #1 check("R2 r3 back to preload", peek_data, 32'd3);
      peek_addr = 5'd1;
      #1 check("R2 r1 back to preload", peek_data, 32'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nbad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

endmodule